// File: doc/BRIEF.md
# Coprocessor Launch Shell with Absolute-Difference Kernel

The block is a small accelerator shell. It holds a byte-wide scratchpad that a host bus and an internal compute engine share, and it has three memory-mapped registers next to that scratchpad: command, status and abort. The host stores the element count and two byte blocks in agreed scratchpad slots. It then writes a function opcode to the command register, and the engine starts on the clock edge that commits that write. The engine sums the absolute differences of the two blocks and stores the 16-bit total in a fixed result slot. It then posts a completion token in the status register. The host learns the job has ended only by polling status; the block has no interrupt.

While a job runs, the engine owns the scratchpad. Host scratchpad accesses are held off with a wait signal and are not applied. Register accesses are always served, so the host can poll status or squash the job at any time. A squash returns the engine to idle, commits no result and posts an aborted code instead of the token.

The engine has three states. S_IDLE waits for a command. S_RUN consumes one element pair per cycle. S_WRES commits the result and sets the token. The transitions are:
- S_IDLE goes to S_RUN on a valid opcode write.
- S_IDLE stays in S_IDLE on an unknown opcode and sets the error code.
- S_RUN stays in S_RUN until the last element.
- S_RUN goes to S_WRES after the last element.
- S_WRES goes to S_IDLE.
- S_RUN or S_WRES goes to S_IDLE on a squash.

Top module: `cop_launch_ctrl`

## Requirements
- R1: After reset the status register reads 0x00 (idle) and h_wait is low.
- R2: With the engine idle, a write of opcode 0x01 to register offset 0 starts the kernel on that write's edge, and status reads 0x01 (busy) in the next cycle. Registers are selected by host address bit 10 = 1, with offsets in address bits 1:0: 0 command, 1 status, 2 abort.
- R3: The kernel computes the sum over i < L of |A[i] - B[i]|. L is the byte in scratchpad slot 0x000, and 0 there means 256. A starts at 0x100 and B at 0x200. The 16-bit sum is stored low byte at 0x001 and high byte at 0x002 no later than the cycle in which status first reads 0xD0 (done).
- R4: The kernel never writes its input blocks.
- R5: A command write while busy is ignored: status stays 0x01 and the running job completes normally.
- R6: A write of any opcode other than 0x01 while idle sets status to 0xEE (error), starts nothing and leaves the result slots unchanged.
- R7: A write with data bit 0 = 1 to register offset 2 while busy makes status read 0xAB (aborted) within two cycles. No result is committed, and the done token never appears for that job.
- R8: A host scratchpad access while busy raises h_wait in the same cycle and is not applied. Register accesses never raise h_wait.
- R9: While idle, host scratchpad writes commit on the clock edge, and reads return data combinationally with h_wait low.
- R10: An abort write while idle leaves status unchanged.
- R11: After an abort, a new launch runs and completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_en | input | 1 | Host access strobe |
| h_we | input | 1 | Host write enable (0 = read) |
| h_addr | input | 11 | Host address; bit 10 selects registers |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, combinational |
| h_wait | output | 1 | Host access held off (scratchpad while busy) |

## Verification
The kernel is exercised with four block patterns:
- A four-element mixed block, with differences of both signs and one zero term, shows that the subtraction direction is chosen per element.
- A full 256-element block of 255 against 0 reaches the largest sum and tests both the length-zero encoding and the high result byte.
- Equal single-element blocks must give zero, which exposes any stale accumulator.
- A three-element run after a squash shows that the abort clears state properly.

Command writes, scratchpad writes and status polls are issued in the middle of a long run. These separate correct arbitration and command-ignore behaviour from designs that let host traffic disturb the engine.

// File: rtl/cop_pkg.sv
package cop_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_WRES = 2'd2
    } eng_state_t;

    localparam logic [7:0] ST_IDLE  = 8'h00;
    localparam logic [7:0] ST_BUSY  = 8'h01;
    localparam logic [7:0] ST_DONE  = 8'hD0;
    localparam logic [7:0] ST_ABORT = 8'hAB;
    localparam logic [7:0] ST_ERR   = 8'hEE;

    localparam logic [7:0] OP_SAD   = 8'h01;

    localparam logic [1:0] REG_CMD   = 2'd0;
    localparam logic [1:0] REG_STAT  = 2'd1;
    localparam logic [1:0] REG_ABORT = 2'd2;
endpackage

// File: rtl/cop_scratch.sv
module cop_scratch #(
    parameter int AW       = 10,
    parameter int DW       = 8,
    parameter int RW       = 16,
    parameter int RES_SLOT = 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          res_we,
    input  logic [RW-1:0] res_data,
    input  logic [AW-1:0] rh_addr,
    output logic [DW-1:0] rh_data,
    input  logic [AW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data
);
    localparam int DEPTH = 1 << AW;
    localparam int NRB   = RW / DW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (res_we) begin
            for (int k = 0; k < NRB; k++) begin
                mem[AW'(RES_SLOT + k)] <= res_data[k*DW +: DW];
            end
        end
    end

    assign rh_data = mem[rh_addr];
    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];
endmodule

// File: rtl/cop_host_dec.sv
module cop_host_dec
    import cop_pkg::*;
#(
    parameter int SP_AW = 10,
    parameter int DW    = 8,
    localparam int HAW  = SP_AW + 1
) (
    input  logic             h_en,
    input  logic             h_we,
    input  logic [HAW-1:0]   h_addr,
    input  logic [DW-1:0]    h_wdata,
    input  logic             busy,
    input  logic [7:0]       status,
    input  logic [DW-1:0]    sp_rdata,
    output logic             sp_we,
    output logic [SP_AW-1:0] sp_addr,
    output logic             cmd_we,
    output logic             abort_we,
    output logic [DW-1:0]    h_rdata,
    output logic             h_wait
);
    logic       sel_reg;
    logic [1:0] off;

    assign sel_reg  = h_addr[SP_AW];
    assign off      = h_addr[1:0];
    assign sp_addr  = h_addr[SP_AW-1:0];
    assign sp_we    = h_en && h_we && !sel_reg && !busy;
    assign cmd_we   = h_en && h_we && sel_reg && (off == REG_CMD);
    assign abort_we = h_en && h_we && sel_reg && (off == REG_ABORT) && h_wdata[0];
    assign h_wait   = h_en && !sel_reg && busy;

    always_comb begin
        if (!sel_reg) begin
            h_rdata = sp_rdata;
        end else if (off == REG_STAT) begin
            h_rdata = DW'(status);
        end else begin
            h_rdata = '0;
        end
    end
endmodule

// File: rtl/cop_sad_engine.sv
module cop_sad_engine
    import cop_pkg::*;
#(
    parameter int SP_AW    = 10,
    parameter int DW       = 8,
    parameter int LEN_MAX  = 256,
    parameter int LEN_SLOT = 0,
    localparam int LW      = $clog2(LEN_MAX + 1),
    localparam int RW      = DW + $clog2(LEN_MAX),
    localparam int A_BASE  = 1 << (SP_AW - 2),
    localparam int B_BASE  = 2 * A_BASE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [7:0]       cmd_op,
    input  logic             abort_we,
    output logic [SP_AW-1:0] ra_addr,
    input  logic [DW-1:0]    ra_data,
    output logic [SP_AW-1:0] rb_addr,
    input  logic [DW-1:0]    rb_data,
    output logic             res_we,
    output logic [RW-1:0]    res_data,
    output logic [7:0]       status,
    output logic             busy
);
    eng_state_t    state, nxt;
    logic [LW-1:0] len_q, idx, len_val;
    logic [RW-1:0] acc;
    logic [DW-1:0] diff;
    logic          last;

    assign len_val = (ra_data == '0) ? LW'(LEN_MAX) : LW'(ra_data);
    assign last    = (idx == len_q - LW'(1));
    assign diff    = (ra_data >= rb_data) ? (ra_data - rb_data) : (rb_data - ra_data);
    assign ra_addr = (state == S_IDLE) ? SP_AW'(LEN_SLOT) : SP_AW'(A_BASE) + SP_AW'(idx);
    assign rb_addr = SP_AW'(B_BASE) + SP_AW'(idx);
    assign busy    = (state != S_IDLE);
    assign res_we  = (state == S_WRES) && !abort_we;
    assign res_data = acc;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (cmd_we && cmd_op == OP_SAD) nxt = S_RUN;
            S_RUN: begin
                if (abort_we)  nxt = S_IDLE;
                else if (last) nxt = S_WRES;
            end
            S_WRES: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= ST_IDLE;
            len_q  <= '0;
            idx    <= '0;
            acc    <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (cmd_we) begin
                        if (cmd_op == OP_SAD) begin
                            status <= ST_BUSY;
                            len_q  <= len_val;
                            idx    <= '0;
                            acc    <= '0;
                        end else begin
                            status <= ST_ERR;
                        end
                    end
                end
                S_RUN: begin
                    if (abort_we) begin
                        status <= ST_ABORT;
                    end else begin
                        acc <= acc + RW'(diff);
                        idx <= idx + LW'(1);
                    end
                end
                S_WRES: status <= abort_we ? ST_ABORT : ST_DONE;
                default: status <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cop_launch_ctrl.sv
module cop_launch_ctrl #(
    parameter int SP_AW    = 10,
    parameter int DW       = 8,
    parameter int LEN_MAX  = 256,
    localparam int HAW     = SP_AW + 1,
    localparam int RW      = DW + $clog2(LEN_MAX),
    localparam int LEN_SLOT = 0,
    localparam int RES_SLOT = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           h_en,
    input  logic           h_we,
    input  logic [HAW-1:0] h_addr,
    input  logic [DW-1:0]  h_wdata,
    output logic [DW-1:0]  h_rdata,
    output logic           h_wait
);
    logic             busy, sp_we, cmd_we, abort_we, res_we;
    logic [7:0]       status;
    logic [SP_AW-1:0] sp_addr, ra_addr, rb_addr;
    logic [DW-1:0]    sp_rdata, ra_data, rb_data;
    logic [RW-1:0]    res_data;

    cop_host_dec #(.SP_AW(SP_AW), .DW(DW)) u_dec (
        .h_en(h_en), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
        .busy(busy), .status(status), .sp_rdata(sp_rdata),
        .sp_we(sp_we), .sp_addr(sp_addr), .cmd_we(cmd_we),
        .abort_we(abort_we), .h_rdata(h_rdata), .h_wait(h_wait)
    );

    cop_scratch #(.AW(SP_AW), .DW(DW), .RW(RW), .RES_SLOT(RES_SLOT)) u_mem (
        .clk(clk), .we(sp_we), .waddr(sp_addr), .wdata(h_wdata),
        .res_we(res_we), .res_data(res_data),
        .rh_addr(sp_addr), .rh_data(sp_rdata),
        .ra_addr(ra_addr), .ra_data(ra_data),
        .rb_addr(rb_addr), .rb_data(rb_data)
    );

    cop_sad_engine #(.SP_AW(SP_AW), .DW(DW), .LEN_MAX(LEN_MAX), .LEN_SLOT(LEN_SLOT)) u_eng (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_op(8'(h_wdata)),
        .abort_we(abort_we), .ra_addr(ra_addr), .ra_data(ra_data),
        .rb_addr(rb_addr), .rb_data(rb_data), .res_we(res_we),
        .res_data(res_data), .status(status), .busy(busy)
    );
endmodule

// File: rtl/cop_launch_chk.sv
module cop_launch_chk
    import cop_pkg::*;
#(
    parameter int HAW = 11
) (
    input logic           clk,
    input logic           rst_n,
    input logic           h_en,
    input logic           h_we,
    input logic [HAW-1:0] h_addr,
    input logic [7:0]     h_wdata,
    input logic           h_wait,
    input logic           busy,
    input logic [7:0]     status,
    input logic           res_we,
    input logic           sp_we
);
    logic reg_acc, cmd_wr, abort_wr;
    assign reg_acc  = h_en && h_addr[HAW-1];
    assign cmd_wr   = reg_acc && h_we && (h_addr[1:0] == REG_CMD);
    assign abort_wr = reg_acc && h_we && (h_addr[1:0] == REG_ABORT) && h_wdata[0];

    p_reg_nowait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_acc |-> !h_wait);

    p_sp_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (h_en && !h_addr[HAW-1] && busy) |-> h_wait);

    p_no_host_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sp_we);

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wr && h_wdata == OP_SAD) |=> (busy && status == ST_BUSY));

    p_cmd_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> (status == ST_BUSY || status == ST_DONE));

    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort_wr) |=> (!busy && status == ST_ABORT));

    p_done_after_res_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |=> (status == ST_DONE));

    p_idle_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && abort_wr && !cmd_wr) |=> $stable(status));
endmodule

bind cop_launch_ctrl cop_launch_chk #(.HAW(HAW)) u_chk (
    .clk(clk), .rst_n(rst_n), .h_en(h_en), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_wait(h_wait), .busy(busy), .status(status),
    .res_we(res_we), .sp_we(sp_we)
);

// File: tb/test_cop_launch_ctrl.sv
module test_cop_launch_ctrl;
    localparam logic [10:0] R_CMD = 11'h400, R_STAT = 11'h401, R_ABT = 11'h402;
    localparam logic [10:0] A_B = 11'h100, B_B = 11'h200;

    logic        clk = 0, rst_n = 0, h_en = 0, h_we = 0;
    logic [10:0] h_addr = '0;
    logic [7:0]  h_wdata = '0, h_rdata;
    logic        h_wait;

    int checks = 0, errors = 0;
    bit finished = 0;
    bit [7:0] ta [256];
    bit [7:0] tb [256];
    logic [23:0] exp_q [$];

    cop_launch_ctrl i_cop_launch_ctrl (
        .clk(clk), .rst_n(rst_n), .h_en(h_en), .h_we(h_we), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .h_wait(h_wait)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [10:0] a, input logic [7:0] d, output logic w);
        @(negedge clk);
        h_en = 1; h_we = 1; h_addr = a; h_wdata = d;
        #2 w = h_wait;
        @(posedge clk); #1 h_en = 0; h_we = 0;
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        logic w;
        bus_wr(a, d, w);
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] d, output logic w);
        @(negedge clk);
        h_en = 1; h_we = 0; h_addr = a;
        #2 d = h_rdata; w = h_wait;
        @(posedge clk); #1 h_en = 0;
    endtask

    function automatic logic [15:0] sad(input int n);
        logic [15:0] s = 0;
        for (int i = 0; i < n; i++)
            s += (ta[i] >= tb[i]) ? 16'(ta[i] - tb[i]) : 16'(tb[i] - ta[i]);
        return s;
    endfunction

    task automatic load(input int n, input logic [7:0] lenb);
        for (int i = 0; i < n; i++) begin
            wr(A_B + 11'(i), ta[i]);
            wr(B_B + 11'(i), tb[i]);
        end
        wr(11'h000, lenb);
    endtask

    // driver side of the scoreboard
    task automatic sb_push(input logic [7:0] st, input logic [15:0] res);
        exp_q.push_back({st, res});
    endtask

    // monitor side: read the outcome through the bus and compare with the queue head
    task automatic sb_take(input string tag);
        logic [7:0] s, lo, hi;
        logic w;
        logic [23:0] e;
        int n = 0;
        do begin
            rd(R_STAT, s, w);
            n++;
        end while (s == 8'h01 && n < 2000);
        rd(11'h001, lo, w);
        rd(11'h002, hi, w);
        if (exp_q.size() == 0) begin
            chk({tag, " scoreboard empty"}, 1, 0);
        end else begin
            e = exp_q.pop_front();
            chk({tag, " status"}, 32'(s), 32'(e[23:16]));
            chk({tag, " result"}, 32'({hi, lo}), 32'(e[15:0]));
        end
    endtask

    initial begin
        logic [7:0] d;
        logic w;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        rd(R_STAT, d, w);
        chk("R1 status after reset", 32'(d), 32'h00);
        chk("R1 wait after reset", 32'(w), 0);

        // R9 idle scratchpad access
        wr(11'h300, 8'h5A);
        rd(11'h300, d, w);
        chk("R9 idle readback", 32'(d), 32'h5A);
        chk("R9 idle no wait", 32'(w), 0);

        // job 1: mixed four-element block
        ta[0] = 10; ta[1] = 200; ta[2] = 7; ta[3] = 0;
        tb[0] = 3;  tb[1] = 250; tb[2] = 7; tb[3] = 9;
        load(4, 8'd4);
        sb_push(8'hD0, sad(4));
        wr(R_CMD, 8'h01);
        rd(R_STAT, d, w);
        chk("R2 busy after launch", 32'(d), 32'h01);
        sb_take("R3 job mixed");
        rd(A_B + 11'd1, d, w);
        chk("R4 block A intact", 32'(d), 32'd200);
        rd(B_B + 11'd3, d, w);
        chk("R4 block B intact", 32'(d), 32'd9);

        // job 2: full length (slot 0 = 0 means 256), maximum sum
        for (int i = 0; i < 256; i++) begin ta[i] = 8'hFF; tb[i] = 8'h00; end
        load(256, 8'd0);
        sb_push(8'hD0, sad(256));
        wr(R_CMD, 8'h01);
        bus_wr(11'h300, 8'h11, w);
        chk("R8 wait on busy write", 32'(w), 1);
        rd(R_STAT, d, w);
        chk("R8 register read no wait", 32'(w), 0);
        wr(R_CMD, 8'h07);
        rd(R_STAT, d, w);
        chk("R5 command ignored while busy", 32'(d), 32'h01);
        sb_take("R3 job full length R5");
        rd(11'h300, d, w);
        chk("R8 busy write not applied", 32'(d), 32'h5A);

        // job 3: equal single-element blocks
        ta[0] = 8'h42; tb[0] = 8'h42;
        load(1, 8'd1);
        sb_push(8'hD0, 16'd0);
        wr(R_CMD, 8'h01);
        sb_take("R3 job equal");
        wr(R_ABT, 8'h01);
        rd(R_STAT, d, w);
        chk("R10 idle abort no effect", 32'(d), 32'hD0);

        // R6 unknown opcode
        wr(R_CMD, 8'h33);
        rd(R_STAT, d, w);
        chk("R6 error code", 32'(d), 32'hEE);
        rd(11'h001, d, w);
        chk("R6 result lo unchanged", 32'(d), 0);

        // R7 abort mid-run
        for (int i = 0; i < 200; i++) begin ta[i] = 8'(i); tb[i] = 8'(255 - i); end
        load(200, 8'd200);
        wr(R_CMD, 8'h01);
        rd(R_STAT, d, w);
        chk("R7 busy before abort", 32'(d), 32'h01);
        wr(R_ABT, 8'h01);
        rd(R_STAT, d, w);
        chk("R7 aborted code", 32'(d), 32'hAB);
        repeat (300) @(posedge clk);
        rd(R_STAT, d, w);
        chk("R7 no late done", 32'(d), 32'hAB);
        rd(11'h001, d, w);
        chk("R7 result lo not committed", 32'(d), 0);
        rd(11'h002, d, w);
        chk("R7 result hi not committed", 32'(d), 0);

        // R11 relaunch after abort
        ta[0] = 1; ta[1] = 90; ta[2] = 33;
        tb[0] = 5; tb[1] = 20; tb[2] = 33;
        load(3, 8'd3);
        sb_push(8'hD0, sad(3));
        wr(R_CMD, 8'h01);
        sb_take("R11 relaunch");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule